// File: doc/BRIEF.md
# Receive Frame Lock and Resync Controller

This block sits behind the receive sampler of a serial link. Each frame carries twelve bit slots: two clock slots and then ten data slots. Every slot lasts a fixed whole number of core clock cycles. The controller looks for the embedded clock edge, which is a high clock slot followed by a low one. It declares frame lock once that edge stays at one slot offset for several frames in a row. While locked, it delivers each frame's ten data bits as a word with a one-cycle valid strobe, together with a recovered word clock.

The lock indicator is active low. The same level drives a resync request output, so it can be wired straight back to the transmitter. The transmitter then sends sync frames for as long as the receiver is out of lock. When lock is lost, the data and recovered-clock outputs are blanked. Lock is reacquired by the same search used after reset. That search tries every slot offset in turn, so ordinary traffic with no dedicated sync pattern is enough to regain lock.

The control core is a three-state machine. **HUNT** waits for any high-then-low slot pair (transition *HUNT→VERIFY*, named *seed*). **VERIFY** re-checks that pair one frame later at the same offset. A pass at the fourth occurrence takes transition *VERIFY→LOCKED*, named *commit*. A miss takes transition *VERIFY→HUNT*, named *reject*, and any other pass stays in VERIFY. **LOCKED** delivers words. A pass or a single miss keeps it in LOCKED, named *hold*. A second consecutive miss takes transition *LOCKED→HUNT*, named *drop*.

Top module: `rx_frame_lock`

## Requirements
- R1: After reset, `lock_n` and `sync_req` are 1, while `word_valid`, `word_data` and `rclk_out` are 0.
- R2: A frame is twelve slots, each held for OVS clock cycles. Slot 0 is the high clock bit (1) and slot 1 is the low clock bit (0). Slots 2 to 11 carry data bits 0 to 9, least significant bit first.
- R3: Lock is declared only after the high-then-low clock pair has appeared at the same slot offset in 4 consecutive frames. After 3 such frames, `lock_n` is still 1.
- R4: `lock_n` is 0 exactly while locked, and `sync_req` always equals `lock_n`.
- R5: While locked, each frame produces exactly one `word_valid` pulse, one cycle long, with that frame's data on `word_data`. The first word is the frame whose clock pair completed the lock.
- R6: A single frame with a wrong clock pair does not drop lock, and that frame's word is still delivered.
- R7: Two consecutive frames with a wrong clock pair drop lock at the second one, and no word is delivered for the second frame.
- R8: While `lock_n` is 1, `word_data` and `rclk_out` are held at 0 and `word_valid` stays 0.
- R9: While locked, `rclk_out` is high for 6·OVS and low for 6·OVS of every 12·OVS cycles.
- R10: From any starting slot offset, with data that contains false high-then-low pairs and no sync pattern, the block reaches lock on the true clock pair and delivers correct words.
- R11: After lock is dropped, the block relocks under the rule of R3, and its first word is again the fourth aligned frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, OVS cycles per bit slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received serial level |
| lock_n | output | 1 | Frame lock indicator, 0 when locked |
| sync_req | output | 1 | Resync request to the transmitter, 1 while unlocked |
| word_data | output | DATA_W | Recovered data word, 0 while unlocked |
| word_valid | output | 1 | One-cycle strobe per recovered word |
| rclk_out | output | 1 | Recovered word clock, 0 while unlocked |

## Verification
On every cycle, the checker confirms four things. A valid strobe occurs only under lock and lasts one cycle. The outputs stay blanked whenever `lock_n` is high. The state machine never goes from HUNT to LOCKED without passing through VERIFY, and every lock release lands in HUNT. Other behaviours need the bench's frame scenarios to show them. These include the count of frames before lock, tolerance of one bad clock pair against loss at two, the mapping of data slots to word bits, the duty of the recovered clock, and locking from an arbitrary offset in traffic full of false pairs.

// File: rtl/rfl_pkg.sv
package rfl_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } rfl_state_e;
endpackage

// File: rtl/rfl_slot_sampler.sv
module rfl_slot_sampler #(
    parameter int OVS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    output logic bit_stb,
    output logic bit_val
);
    localparam int PH_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [PH_W-1:0] LAST_PH   = PH_W'(OVS - 1);
    localparam logic [PH_W-1:0] SAMPLE_PH = PH_W'(OVS / 2);

    logic [PH_W-1:0] ph_q;
    logic            rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
            rx_q <= 1'b0;
        end else begin
            rx_q <= rx_bit;
            ph_q <= (ph_q == LAST_PH) ? '0 : ph_q + 1'b1;
        end
    end

    assign bit_stb = (ph_q == SAMPLE_PH);
    assign bit_val = rx_q;
endmodule

// File: rtl/rfl_shift.sv
module rfl_shift #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic         din,
    output logic [W-1:0] sh
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sh <= '0;
        else if (stb) sh <= {sh[W-2:0], din};
    end
endmodule

// File: rtl/rfl_slot_ctr.sv
module rfl_slot_ctr #(
    parameter int FRAME_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       stb,
    input  logic                       seed,
    output logic [$clog2(FRAME_W)-1:0] pos,
    output logic [$clog2(FRAME_W)-1:0] pos_nxt
);
    localparam int POS_W = $clog2(FRAME_W);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_W - 1);
    localparam logic [POS_W-1:0] SEED_POS = POS_W'(1);

    assign pos_nxt = (pos == LAST) ? '0 : pos + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pos <= '0;
        else if (stb) pos <= seed ? SEED_POS : pos_nxt;
    end
endmodule

// File: rtl/rx_frame_lock.sv
module rx_frame_lock
    import rfl_pkg::*;
#(
    parameter int OVS         = 4,
    parameter int DATA_W      = 10,
    parameter int LOCK_FRAMES = 4,
    parameter int MISS_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    output logic              lock_n,
    output logic              sync_req,
    output logic [DATA_W-1:0] word_data,
    output logic              word_valid,
    output logic              rclk_out
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int POS_W   = $clog2(FRAME_W);
    localparam int HIT_W   = $clog2(LOCK_FRAMES + 1);
    localparam int MISS_W  = $clog2(MISS_FRAMES + 1);
    localparam logic [POS_W-1:0]  CHK_POS  = POS_W'(1);
    localparam logic [POS_W-1:0]  END_POS  = POS_W'(FRAME_W - 1);
    localparam logic [POS_W-1:0]  HALF_POS = POS_W'(FRAME_W / 2);
    localparam logic [HIT_W-1:0]  HIT_LAST = HIT_W'(LOCK_FRAMES - 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_FRAMES - 1);

    rfl_state_e        state_q, state_d;
    logic              bit_stb, bit_val;
    logic [DATA_W-1:0] sh;
    logic [POS_W-1:0]  pos, pos_nxt;
    logic [HIT_W-1:0]  hit_q;
    logic [MISS_W-1:0] miss_q;
    logic              pair_ok, at_chk, at_end, seed;
    logic [DATA_W-1:0] word_d;
    logic              lock_n_q;

    rfl_slot_sampler #(.OVS(OVS)) u_smp (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit),
        .bit_stb(bit_stb), .bit_val(bit_val)
    );

    rfl_shift #(.W(DATA_W)) u_sh (
        .clk(clk), .rst_n(rst_n), .stb(bit_stb), .din(bit_val), .sh(sh)
    );

    rfl_slot_ctr #(.FRAME_W(FRAME_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .stb(bit_stb), .seed(seed),
        .pos(pos), .pos_nxt(pos_nxt)
    );

    // high clock slot just before, low clock slot now
    assign pair_ok = sh[0] & ~bit_val;
    assign at_chk  = bit_stb && (pos_nxt == CHK_POS);
    assign at_end  = bit_stb && (pos_nxt == END_POS);
    assign seed    = (state_q == ST_HUNT) && pair_ok;

    // slot 2 lands in bit 0 of the word
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            word_d[i] = (i == 0) ? bit_val : sh[i-1];
        end
        word_d = {<<{word_d}};
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (bit_stb && pair_ok) state_d = ST_VERIFY;               // seed
            end
            ST_VERIFY: begin
                if (at_chk) begin
                    if (!pair_ok)               state_d = ST_HUNT;          // reject
                    else if (hit_q == HIT_LAST) state_d = ST_LOCKED;        // commit
                end
            end
            ST_LOCKED: begin
                if (at_chk && !pair_ok && miss_q == MISS_LAST) state_d = ST_HUNT; // drop
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // state register and frame counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            hit_q   <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HUNT && bit_stb && pair_ok) hit_q <= HIT_W'(1);
            else if (state_q == ST_VERIFY && at_chk && pair_ok) hit_q <= hit_q + 1'b1;
            if (state_q != ST_LOCKED) miss_q <= '0;
            else if (at_chk) miss_q <= pair_ok ? '0 : miss_q + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_n_q   <= 1'b1;
            word_valid <= 1'b0;
            word_data  <= '0;
            rclk_out   <= 1'b0;
        end else begin
            lock_n_q   <= (state_d != ST_LOCKED);
            word_valid <= 1'b0;
            if (state_d != ST_LOCKED) begin
                word_data <= '0;
                rclk_out  <= 1'b0;
            end else begin
                if (state_q == ST_LOCKED && at_end) begin
                    word_valid <= 1'b1;
                    word_data  <= word_d;
                end
                if (bit_stb) rclk_out <= (pos_nxt < HALF_POS);
            end
        end
    end

    assign lock_n   = lock_n_q;
    assign sync_req = lock_n_q;
endmodule

// File: rtl/rfl_checker.sv
module rfl_checker
    import rfl_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lock_n,
    input logic              word_valid,
    input logic [DATA_W-1:0] word_data,
    input logic              rclk_out,
    input rfl_state_e        state
);
    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !lock_n);                                                      // R5
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);                                                  // R5
    AST_BLANK_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_n |-> (word_data == '0 && !rclk_out && !word_valid));                    // R8
    AST_LOCK_VIA_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> ($past(state) == ST_VERIFY && state == ST_LOCKED));         // R3
    AST_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |=> (state != ST_LOCKED));                                 // R3
    AST_DROP_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_n) |-> (state == ST_HUNT));                                        // R7
endmodule

bind rx_frame_lock rfl_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lock_n(lock_n), .word_valid(word_valid),
    .word_data(word_data), .rclk_out(rclk_out), .state(state_q)
);

// File: tb/sim_rx_frame_lock.sv
`timescale 1ns/1ps
module sim_rx_frame_lock;
    localparam int OVS = 4;
    localparam int DW  = 10;
    localparam int FW  = DW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_bit = 1'b0;
    logic          lock_n, sync_req, word_valid, rclk_out;
    logic [DW-1:0] word_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit mon_en  = 1'b1;
    bit done    = 1'b0;
    logic [DW-1:0] exp_q[$];

    always #4 clk = ~clk;

    rx_frame_lock #(.OVS(OVS), .DATA_W(DW), .LOCK_FRAMES(4), .MISS_FRAMES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .lock_n(lock_n),
        .sync_req(sync_req), .word_data(word_data), .word_valid(word_valid),
        .rclk_out(rclk_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rx_bit = b;
        repeat (OVS) @(negedge clk);
    endtask

    // R2: slot0=1, slot1=0, data LSB first; good=0 corrupts slot0 to 0
    task automatic send_frame(input logic [DW-1:0] d, input bit good, input bit push);
        if (push) exp_q.push_back(d);
        send_bit(good);
        send_bit(1'b0);
        for (int i = 0; i < DW; i++) send_bit(d[i]);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (word_valid && lock_n) check(1'b0, "R8 valid while unlocked", 1, 0);
            if (word_valid && mon_en) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R7 unexpected word", int'(word_data), 0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(word_data == e, "R5 word", int'(word_data), int'(e));
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int hi;
        repeat (5) @(negedge clk);
        // R1
        check(lock_n == 1'b1 && sync_req == 1'b1, "R1 lock/sync", {lock_n, sync_req}, 3);
        check(word_valid == 0 && word_data == 0 && rclk_out == 0, "R1 outputs",
              {word_valid, rclk_out}, 0);
        rst_n = 1'b1;

        // R3: three aligned frames are not enough
        send_frame(10'h2C6, 1, 0);
        send_frame(10'h0F3, 1, 0);
        send_frame(10'h35A, 1, 0);
        check(lock_n == 1'b1, "R3 still hunting after 3", lock_n, 1);
        send_frame(10'h1E1, 1, 1);
        check(lock_n == 1'b0, "R3 locked after 4", lock_n, 0);
        check(sync_req == lock_n, "R4 sync follows lock", sync_req, lock_n);
        send_frame(10'h3FF, 1, 1);
        send_frame(10'h001, 1, 1);
        send_frame(10'h200, 1, 1);

        // R9: clock duty over one frame
        hi = 0;
        fork
            send_frame(10'h155, 1, 1);
            for (int k = 0; k < FW * OVS; k++) begin
                @(negedge clk);
                if (rclk_out) hi++;
            end
        join
        check(hi == 6 * OVS, "R9 rclk high cycles", hi, 6 * OVS);

        // R6: one bad clock pair
        send_frame(10'h0AA, 0, 1);
        check(lock_n == 1'b0, "R6 lock kept after one miss", lock_n, 0);
        send_frame(10'h123, 1, 1);
        send_frame(10'h000, 0, 1);
        send_frame(10'h321, 1, 1);
        check(lock_n == 1'b0, "R6 lock kept, misses not consecutive", lock_n, 0);

        // R7: two consecutive bad pairs
        send_frame(10'h000, 0, 1);
        send_frame(10'h000, 0, 0);
        check(lock_n == 1'b1, "R7 lock dropped", lock_n, 1);
        check(sync_req == 1'b1, "R4 sync requested", sync_req, 1);
        check(word_data == 0 && rclk_out == 0, "R8 outputs blanked", int'(word_data), 0);

        // R11: relock
        send_frame(10'h0C3, 1, 0);
        send_frame(10'h3C0, 1, 0);
        send_frame(10'h2A5, 1, 0);
        check(lock_n == 1'b1 && word_data == 0, "R11/R8 blank during verify", lock_n, 1);
        send_frame(10'h111, 1, 1);
        check(lock_n == 1'b0, "R11 relocked", lock_n, 0);
        send_frame(10'h222, 1, 1);
        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R5 all words seen", exp_q.size(), 0);

        // R10: arbitrary offset, false pairs, no sync pattern
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(lock_n == 1'b1, "R1 reset relock state", lock_n, 1);
        rst_n = 1'b1;
        mon_en = 1'b0;
        send_bit(1); send_bit(1); send_bit(0); send_bit(1); send_bit(0);
        for (int f = 0; f < 16; f++)
            send_frame((f % 2) ? (10'h2B5 ^ DW'(f)) : 10'h000, 1, 0);
        fork
            send_frame(10'h2B5 ^ 10'h011, 1, 1);
            begin
                repeat (3 * OVS) @(negedge clk);
                mon_en = 1'b1;
            end
        join
        send_frame(10'h000, 1, 1);
        send_frame(10'h2B5 ^ 10'h013, 1, 1);
        send_frame(10'h000, 1, 1);
        repeat (8) @(negedge clk);
        check(lock_n == 1'b0, "R10 locked on random data", lock_n, 0);
        check(exp_q.size() == 0, "R10 words delivered", exp_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule